// File: doc/BRIEF.md
# Scanned Lamp Matrix Output Stage

This block is the output stage for a lamp grid of nine rows by eight columns, controlled through three write-only byte registers on a small 8-bit processor bus. One register sinks rows 1 to 8, a second register sinks row 9 on its own, and a third drives the eight columns. A lamp lights only while its row is sunk and its column is driven. Software scans the grid itself: it blanks the row and column registers, loads the next column pattern, and then asserts the next row.

The sink line of row 1 is also brought out as a keep-alive strobe for an external watchdog. Each time software scans row 1 the strobe pulses, so a scan loop that stops also stops the strobe. A reset from the supervisor clears all three registers, and every lamp goes dark.

Top module: `lampmx_driver`

## Requirements
- R1: A register is written on the rising clock edge where `bus_cs` and `bus_we` are both high. The 4-bit offset `bus_addr` selects the register: 8 is the row register, 9 is the extra-row register and 10 (hex A) is the column register. The new value appears on the outputs directly after that edge.
- R2: Bit n of the row register (n = 0..7) drives `row_sink[n]`. Bit 0 is row 1.
- R3: Bit 0 of the extra-row register drives `row_sink[8]` (row 9). Bits 7 to 1 of a write to that register have no effect.
- R4: Bit c of the column register drives `col_drive[c]`.
- R5: `lamp_on[r*8+c]` is high exactly when `row_sink[r]` and `col_drive[c]` are both high. This holds for any number of rows and columns that are active at the same time, because the row value is passed through and one-hot coding is not enforced.
- R6: A write with `bus_cs` low, with `bus_we` low, or with an offset other than 8, 9 or 10 changes no output.
- R7: Writing zero to the row register or to the column register turns off every lamp that register enabled, starting from the cycle after the write edge.
- R8: `wdog_strobe` follows the row-1 sink line. Outside reset it falls only on a row-register write that has bit 0 clear.
- R9: While `rst_n` is low, all registers are cleared and `row_sink`, `col_drive`, `lamp_on` and `wdog_strobe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset from the supervisor |
| bus_cs | input | 1 | Chip select for the lamp register window |
| bus_we | input | 1 | Write enable |
| bus_addr | input | 4 | Register offset within the window |
| bus_wdata | input | 8 | Write data byte |
| row_sink | output | 9 | Row sink enables; bit 8 is row 9 |
| col_drive | output | 8 | Column source enables |
| lamp_on | output | 72 | Lit state for each crossing, index row*8+column |
| wdog_strobe | output | 1 | Keep-alive strobe taken from the row-1 sink |

## Verification
Decoding the registers is simple. The harder case is the ghost-free scan order. A lamp must stay dark while the column data for one row is present and a different row is still sunk. The bench reproduces this by blanking all three registers before it loads each column pattern and before it asserts each row, and it compares the full 72-lamp vector after every step. The strobe falling edge is forced only through row writes that clear bit 0, and writes to the extra-row register use upper bits that must be ignored.

// File: rtl/lampmx_pkg.sv
package lampmx_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ROW  = 2'd1,
        SEL_XROW = 2'd2,
        SEL_COL  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/lampmx_dec.sv
module lampmx_dec
    import lampmx_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int ROW_OFS  = 8,
    parameter int XROW_OFS = 9,
    parameter int COL_OFS  = 10
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] ROW_A  = ADDR_W'(ROW_OFS);
    localparam logic [ADDR_W-1:0] XROW_A = ADDR_W'(XROW_OFS);
    localparam logic [ADDR_W-1:0] COL_A  = ADDR_W'(COL_OFS);

    always_comb begin
        sel = SEL_NONE;
        if (cs && we) begin
            unique case (addr)
                ROW_A:   sel = SEL_ROW;
                XROW_A:  sel = SEL_XROW;
                COL_A:   sel = SEL_COL;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lampmx_regs.sv
module lampmx_regs
    import lampmx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ROWS_MAIN = 8,
    parameter int COLS      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  reg_sel_e             sel,
    input  logic [DATA_W-1:0]    wdata,
    output logic [ROWS_MAIN-1:0] row_q,
    output logic                 xrow_q,
    output logic [COLS-1:0]      col_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            xrow_q <= 1'b0;
            col_q  <= '0;
        end else begin
            unique case (sel)
                SEL_ROW:  row_q  <= wdata[ROWS_MAIN-1:0];
                SEL_XROW: xrow_q <= wdata[0];
                SEL_COL:  col_q  <= wdata[COLS-1:0];
                default:  ;
            endcase
        end
    end

    assert_row_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_ROW) |=> (row_q == $past(wdata[ROWS_MAIN-1:0])));
    assert_xrow_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_XROW) |=> (xrow_q == $past(wdata[0])));
    assert_col_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_COL) |=> (col_q == $past(wdata[COLS-1:0])));
endmodule

// File: rtl/lampmx_grid.sv
module lampmx_grid #(
    parameter int ROWS = 9,
    parameter int COLS = 8
) (
    input  logic [ROWS-1:0]      rows,
    input  logic [COLS-1:0]      cols,
    output logic [ROWS*COLS-1:0] lit
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign lit[r*COLS+c] = rows[r] & cols[c];
        end
    end
endmodule

// File: rtl/lampmx_driver.sv
module lampmx_driver
    import lampmx_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int ROWS_MAIN = 8,
    parameter int COLS      = 8,
    parameter int ROW_OFS   = 8,
    parameter int XROW_OFS  = 9,
    parameter int COL_OFS   = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_cs,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [ROWS_MAIN:0]          row_sink,
    output logic [COLS-1:0]             col_drive,
    output logic [(ROWS_MAIN+1)*COLS-1:0] lamp_on,
    output logic                        wdog_strobe
);
    localparam int ROWS = ROWS_MAIN + 1;

    reg_sel_e             sel;
    logic [ROWS_MAIN-1:0] row_q;
    logic                 xrow_q;
    logic [COLS-1:0]      col_q;

    lampmx_dec #(
        .ADDR_W(ADDR_W), .ROW_OFS(ROW_OFS), .XROW_OFS(XROW_OFS), .COL_OFS(COL_OFS)
    ) u_dec (
        .cs(bus_cs), .we(bus_we), .addr(bus_addr), .sel(sel)
    );

    lampmx_regs #(
        .DATA_W(DATA_W), .ROWS_MAIN(ROWS_MAIN), .COLS(COLS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(bus_wdata),
        .row_q(row_q), .xrow_q(xrow_q), .col_q(col_q)
    );

    assign row_sink    = {xrow_q, row_q};
    assign col_drive   = col_q;
    assign wdog_strobe = row_q[0];

    lampmx_grid #(.ROWS(ROWS), .COLS(COLS)) u_grid (
        .rows(row_sink), .cols(col_drive), .lit(lamp_on)
    );

    assert_lamp_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lamp_on) == $countones(row_sink) * $countones(col_drive));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_we) |=> ($stable(row_sink) && $stable(col_drive)));
    assert_strobe_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog_strobe) |-> $past(bus_cs && bus_we &&
            (bus_addr == ADDR_W'(ROW_OFS)) && !bus_wdata[0]));
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |-> (row_sink == '0 && col_drive == '0 && lamp_on == '0 && !wdog_strobe));
endmodule

// File: tb/lampmx_driver_tb_top.sv
module lampmx_driver_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [8:0]  row_sink;
    logic [7:0]  col_drive;
    logic [71:0] lamp_on;
    logic        wdog_strobe;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_row = '0;
    logic       m_xrow = 1'b0;
    logic [7:0] m_col = '0;

    always #4 clk = ~clk;

    lampmx_driver dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .row_sink(row_sink),
        .col_drive(col_drive), .lamp_on(lamp_on), .wdog_strobe(wdog_strobe)
    );

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [71:0] exp_lamps();
        logic [71:0] v = '0;
        logic [8:0]  rs = {m_xrow, m_row};
        for (int r = 0; r < 9; r++)
            for (int c = 0; c < 8; c++)
                v[r*8+c] = rs[r] & m_col[c];
        return v;
    endfunction

    task automatic check_all(input string req);
        chk({req, " row_sink"}, 72'(row_sink), 72'({m_xrow, m_row}));
        chk({req, " col_drive"}, 72'(col_drive), 72'(m_col));
        chk({req, " lamp_on"}, lamp_on, exp_lamps());
        chk({req, " wdog_strobe"}, 72'(wdog_strobe), 72'(m_row[0]));
    endtask

    task automatic bus_wr(input logic cs, input logic we, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = cs; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
        if (cs && we) begin
            if (a == 4'h8) m_row = d;
            if (a == 4'h9) m_xrow = d[0];
            if (a == 4'hA) m_col = d;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog timeout");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pat;
        repeat (3) @(negedge clk);
        check_all("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 after release");

        // R1 R2 R3 R4 R5 R7: blank-load-assert scan for every row and column pattern
        for (int r = 0; r < 9; r++) begin
            for (int p = 0; p < 10; p++) begin
                pat = (p < 8) ? (8'h01 << p) : ((p == 8) ? 8'hA5 : 8'hFF);
                bus_wr(1, 1, 4'h8, 8'h00);
                bus_wr(1, 1, 4'h9, 8'h00);
                bus_wr(1, 1, 4'hA, 8'h00);
                check_all("R7 blanked");
                bus_wr(1, 1, 4'hA, pat);
                check_all("R4 column only");
                if (r < 8) bus_wr(1, 1, 4'h8, 8'h01 << r);
                else       bus_wr(1, 1, 4'h9, 8'h01);
                check_all("R5 scan");
            end
        end

        // R5: several rows and columns together
        bus_wr(1, 1, 4'h8, 8'h5A);
        bus_wr(1, 1, 4'h9, 8'h01);
        bus_wr(1, 1, 4'hA, 8'hC3);
        check_all("R5 multi");
        bus_wr(1, 1, 4'h8, 8'hFF);
        bus_wr(1, 1, 4'hA, 8'hFF);
        chk("R5 all lit", lamp_on, {72{1'b1}});

        // R3: upper bits of the extra-row register are ignored
        bus_wr(1, 1, 4'h9, 8'hFE);
        check_all("R3 upper bits");
        chk("R3 row9 off", 72'(row_sink[8]), 72'd0);
        bus_wr(1, 1, 4'h9, 8'h81);
        check_all("R3 bit0");

        // R6: writes that must not land
        bus_wr(1, 1, 4'hA, 8'h00);
        bus_wr(0, 1, 4'hA, 8'hFF);
        check_all("R6 cs low");
        bus_wr(1, 0, 4'hA, 8'hFF);
        check_all("R6 we low");
        for (int a = 0; a < 16; a++) begin
            if (a >= 8 && a <= 10) continue;
            bus_wr(1, 1, 4'(a), 8'h00);
            check_all("R6 other offset");
        end

        // R7: zeroing the column register blanks immediately
        bus_wr(1, 1, 4'hA, 8'h3C);
        check_all("R7 lit");
        bus_wr(1, 1, 4'hA, 8'h00);
        chk("R7 col zero", lamp_on, 72'd0);
        bus_wr(1, 1, 4'hA, 8'h3C);
        bus_wr(1, 1, 4'h9, 8'h00);
        bus_wr(1, 1, 4'h8, 8'h00);
        chk("R7 row zero", lamp_on, 72'd0);

        // R8: strobe follows row 1
        bus_wr(1, 1, 4'h8, 8'h01);
        chk("R8 strobe high", 72'(wdog_strobe), 72'd1);
        bus_wr(1, 1, 4'h9, 8'h00);
        chk("R8 strobe held", 72'(wdog_strobe), 72'd1);
        bus_wr(1, 1, 4'h8, 8'h02);
        chk("R8 strobe low", 72'(wdog_strobe), 72'd0);
        bus_wr(1, 1, 4'h8, 8'h01);
        check_all("R8 re-assert");

        // R9: reset in the middle of operation
        bus_wr(1, 1, 4'h9, 8'h01);
        bus_wr(1, 1, 4'hA, 8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        m_row = '0; m_xrow = 1'b0; m_col = '0;
        check_all("R9 mid reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 post reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule